// File: doc/BRIEF.md
# Sign-Sign LMS Coefficient Bank

This block holds the adaptive coefficients of a sixteen-band noise canceller and adjusts them with the sign-sign LMS rule. A comparator outside the block resolves whether the residual error is negative, and each band of an analog filter bank supplies the polarity of its own signal. On each clock where updates are enabled, every band compares the two polarities. Where they agree, the band's 8-bit coefficient goes up by one. Where they differ, it goes down by one. The coefficients stop at 0 and at 255 and never wrap.

Each coefficient also leaves the block as a registered unit-element thermometer code that switches a matched capacitor array on the analog side. The number of asserted elements equals the coefficient. The code follows the coefficient one clock later.

Each band cell is a small state machine whose state is the saturation zone of its counter. ZN_FLOOR means the coefficient is 0, ZN_MID means it is strictly inside the range, and ZN_CEIL means it is 255. The per-cycle step decision is STEP_HOLD, STEP_UP or STEP_DOWN. The zone transitions are:
- T_LEAVE_FLOOR: ZN_FLOOR to ZN_MID on STEP_UP.
- T_REACH_CEIL: ZN_MID to ZN_CEIL when STEP_UP makes the coefficient 255.
- T_LEAVE_CEIL: ZN_CEIL to ZN_MID on STEP_DOWN.
- T_REACH_FLOOR: ZN_MID to ZN_FLOOR when STEP_DOWN makes the coefficient 0.

Every other case stays in its zone. A STEP_DOWN in ZN_FLOOR or a STEP_UP in ZN_CEIL is a saturation hold.

Top module: `sslms_bank`

## Requirements
- R1: A synchronous active-high reset loads every coefficient with INIT_WEIGHT (default 128) and loads every thermometer output with the matching code. Reset takes priority over update enable.
- R2: A sign input of 1 means negative. When upd_en is 1 and err_sign equals band_sign[k], coefficient k increases by one at the clock edge. When they differ, it decreases by one.
- R3: When upd_en is 0, no coefficient changes, whatever the sign inputs are.
- R4: A coefficient at 255 that is told to increase stays at 255.
- R5: A coefficient at 0 that is told to decrease stays at 0.
- R6: Thermometer bit i of band k (therm_o[k*255+i]) is 1 exactly when the coefficient of band k, as it stood one clock earlier, is greater than i.
- R7: All sixteen bands update in the same clock edge, each from its own sign bit.
- R8: Holding one direction drives a coefficient from 0 to 255 in 255 steps, and reversing the direction drives it back to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Update clock |
| rst | input | 1 | Synchronous reset, active high |
| upd_en | input | 1 | Enables coefficient steps |
| err_sign | input | 1 | Residual error polarity, 1 = negative |
| band_sign | input | 16 | Per-band signal polarity, bit k for band k, 1 = negative |
| weight_o | output | 128 | Coefficients, band k in bits [8k+7:8k] |
| therm_o | output | 4080 | Thermometer codes, band k in bits [255k+254:255k] |

## Verification
Saturation holds and ordinary steps fall in the same cycle whenever some bands sit at a limit while others are inside the range. A mixed band_sign pattern is therefore applied after a full sweep has pinned every band at 0, so that some bands leave the floor while the rest hold there in the same edge. Reset and enable also coincide: reset is asserted with upd_en high and sign patterns that would otherwise move the coefficients. Each case is judged by comparing every coefficient and every thermometer code against an independent model queued by the driver.

// File: rtl/sslms_pkg.sv
package sslms_pkg;

    typedef enum logic [1:0] {
        ZN_FLOOR = 2'd0,
        ZN_MID   = 2'd1,
        ZN_CEIL  = 2'd2
    } zone_t;

    typedef enum logic [1:0] {
        STEP_HOLD = 2'd0,
        STEP_UP   = 2'd1,
        STEP_DOWN = 2'd2
    } step_t;

endpackage

// File: rtl/sslms_therm_enc.sv
module sslms_therm_enc #(
    parameter  int WEIGHT_W = 8,
    localparam int THERM_W  = (1 << WEIGHT_W) - 1
) (
    input  logic [WEIGHT_W-1:0] value_i,
    output logic [THERM_W-1:0]  code_o
);

    for (genvar i = 0; i < THERM_W; i++) begin : g_elem
        assign code_o[i] = (value_i > WEIGHT_W'(i));
    end

endmodule

// File: rtl/sslms_cell.sv
module sslms_cell
    import sslms_pkg::*;
#(
    parameter  int WEIGHT_W    = 8,
    parameter  int INIT_WEIGHT = 128,
    localparam int THERM_W     = (1 << WEIGHT_W) - 1
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en,
    input  logic                err_sign,
    input  logic                band_sign,
    output logic [WEIGHT_W-1:0] weight_o,
    output logic [THERM_W-1:0]  therm_o
);

    localparam logic [WEIGHT_W-1:0] W_MAX  = '1;
    localparam logic [WEIGHT_W-1:0] W_MIN  = '0;
    localparam logic [WEIGHT_W-1:0] W_ONE  = WEIGHT_W'(1);
    localparam logic [WEIGHT_W-1:0] W_INIT = WEIGHT_W'(INIT_WEIGHT);
    localparam zone_t Z_INIT = (W_INIT == W_MIN) ? ZN_FLOOR :
                               (W_INIT == W_MAX) ? ZN_CEIL  : ZN_MID;

    zone_t                zone_q, zone_d;
    step_t                step;
    logic [WEIGHT_W-1:0]  w_q, w_d;
    logic [WEIGHT_W-1:0]  w_inc, w_dec;
    logic [WEIGHT_W-1:0]  enc_in;
    logic [THERM_W-1:0]   enc_code;
    logic [THERM_W-1:0]   therm_q;
    logic                 agree;

    assign agree = ~(err_sign ^ band_sign);
    assign w_inc = w_q + W_ONE;
    assign w_dec = w_q - W_ONE;

    // step decision
    always_comb begin
        step = STEP_HOLD;
        if (en) begin
            step = agree ? STEP_UP : STEP_DOWN;
        end
    end

    // zone transitions and next coefficient
    always_comb begin
        zone_d = zone_q;
        w_d    = w_q;
        unique case (zone_q)
            ZN_FLOOR: begin
                if (step == STEP_UP) begin
                    w_d    = w_inc;
                    zone_d = (w_inc == W_MAX) ? ZN_CEIL : ZN_MID;
                end
            end
            ZN_MID: begin
                if (step == STEP_UP) begin
                    w_d    = w_inc;
                    zone_d = (w_inc == W_MAX) ? ZN_CEIL : ZN_MID;
                end else if (step == STEP_DOWN) begin
                    w_d    = w_dec;
                    zone_d = (w_dec == W_MIN) ? ZN_FLOOR : ZN_MID;
                end
            end
            ZN_CEIL: begin
                if (step == STEP_DOWN) begin
                    w_d    = w_dec;
                    zone_d = (w_dec == W_MIN) ? ZN_FLOOR : ZN_MID;
                end
            end
            default: begin
                zone_d = Z_INIT;
                w_d    = W_INIT;
            end
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            zone_q <= Z_INIT;
            w_q    <= W_INIT;
        end else begin
            zone_q <= zone_d;
            w_q    <= w_d;
        end
    end

    // outputs
    assign enc_in = rst ? W_INIT : w_q;

    sslms_therm_enc #(.WEIGHT_W(WEIGHT_W)) u_enc (
        .value_i (enc_in),
        .code_o  (enc_code)
    );

    always_ff @(posedge clk) begin
        therm_q <= enc_code;
    end

    assign weight_o = w_q;
    assign therm_o  = therm_q;

    // checks
    logic armed_q;
    always_ff @(posedge clk) begin
        if (rst) armed_q <= 1'b0;
        else     armed_q <= 1'b1;
    end

    AST_STEP_UP: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_UP && w_q != W_MAX) |=> (w_q == $past(w_q) + W_ONE)); // R2
    AST_STEP_DOWN: assert property (@(posedge clk) disable iff (rst)
        (step == STEP_DOWN && w_q != W_MIN) |=> (w_q == $past(w_q) - W_ONE)); // R2
    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(w_q)); // R3
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (rst)
        (en && agree && w_q == W_MAX) |=> (w_q == W_MAX)); // R4
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (rst)
        (en && !agree && w_q == W_MIN) |=> (w_q == W_MIN)); // R5
    AST_THERM_LAG: assert property (@(posedge clk) disable iff (rst)
        armed_q |-> ($countones(therm_q) == int'($past(w_q)))); // R6

endmodule

// File: rtl/sslms_bank.sv
module sslms_bank #(
    parameter  int NUM_BANDS   = 16,
    parameter  int WEIGHT_W    = 8,
    parameter  int INIT_WEIGHT = 128,
    localparam int THERM_W     = (1 << WEIGHT_W) - 1
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          upd_en,
    input  logic                          err_sign,
    input  logic [NUM_BANDS-1:0]          band_sign,
    output logic [NUM_BANDS*WEIGHT_W-1:0] weight_o,
    output logic [NUM_BANDS*THERM_W-1:0]  therm_o
);

    for (genvar b = 0; b < NUM_BANDS; b++) begin : g_band
        sslms_cell #(
            .WEIGHT_W    (WEIGHT_W),
            .INIT_WEIGHT (INIT_WEIGHT)
        ) u_cell (
            .clk       (clk),
            .rst       (rst),
            .en        (upd_en),
            .err_sign  (err_sign),
            .band_sign (band_sign[b]),
            .weight_o  (weight_o[b*WEIGHT_W +: WEIGHT_W]),
            .therm_o   (therm_o[b*THERM_W +: THERM_W])
        );
    end

endmodule

// File: tb/sim_sslms_bank.sv
`timescale 1ns/1ps
module sim_sslms_bank;

    localparam int NB = 16;
    localparam int WW = 8;
    localparam int TW = 255;

    typedef struct {
        logic [NB*WW-1:0] w;
        logic [NB*WW-1:0] t;
        string            tag;
    } item_t;

    logic                clk = 1'b0;
    logic                rst = 1'b1;
    logic                upd_en = 1'b0;
    logic                err_sign = 1'b0;
    logic [NB-1:0]       band_sign = '0;
    logic [NB*WW-1:0]    weight_o;
    logic [NB*TW-1:0]    therm_o;

    int checks = 0;
    int fails  = 0;
    bit done   = 0;
    item_t q[$];
    logic [WW-1:0] model [NB];

    always #2 clk = ~clk;

    sslms_bank u0 (
        .clk       (clk),
        .rst       (rst),
        .upd_en    (upd_en),
        .err_sign  (err_sign),
        .band_sign (band_sign),
        .weight_o  (weight_o),
        .therm_o   (therm_o)
    );

    function automatic logic [NB*WW-1:0] pack_model();
        logic [NB*WW-1:0] v;
        for (int k = 0; k < NB; k++) v[k*WW +: WW] = model[k];
        return v;
    endfunction

    task automatic drive(input logic r, input logic en, input logic e,
                         input logic [NB-1:0] b, input string tag);
        item_t it;
        @(negedge clk);
        rst = r; upd_en = en; err_sign = e; band_sign = b;
        it.t = pack_model();
        if (r) begin
            for (int k = 0; k < NB; k++) model[k] = 8'd128;
            it.t = pack_model();
        end else if (en) begin
            for (int k = 0; k < NB; k++) begin
                if (e == b[k]) begin
                    if (model[k] != 8'd255) model[k] = model[k] + 8'd1;
                end else begin
                    if (model[k] != 8'd0) model[k] = model[k] - 8'd1;
                end
            end
        end
        it.w = pack_model();
        it.tag = tag;
        q.push_back(it);
    endtask

    // monitor / scoreboard
    always @(posedge clk) begin
        #1;
        if (q.size() > 0 && !done) begin
            item_t it;
            logic [NB*TW-1:0] exp_t;
            it = q.pop_front();
            for (int k = 0; k < NB; k++)
                for (int i = 0; i < TW; i++)
                    exp_t[k*TW + i] = (it.t[k*WW +: WW] > WW'(i));
            checks++;
            if (weight_o !== it.w) begin
                fails++;
                $display("FAIL %s weights actual=%h expected=%h", it.tag, weight_o, it.w);
            end
            checks++;
            if (therm_o !== exp_t) begin
                fails++;
                $display("FAIL R6 (%s) thermometer actual=%h expected=%h", it.tag, therm_o, exp_t);
            end
        end
    end

    task automatic report();
        if (!done) begin
            done = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog actual=timeout expected=completion");
        report();
    end

    initial begin
        for (int k = 0; k < NB; k++) model[k] = 8'd128;
        // R1 reset state
        drive(1, 0, 0, '0, "R1 reset");
        drive(0, 0, 0, '0, "R1 idle after reset");
        // R2 / R7 mixed per-band directions
        drive(0, 1, 0, 16'h00FF, "R2 R7 err positive");
        drive(0, 1, 1, 16'hA5C3, "R2 R7 err negative");
        drive(0, 1, 0, 16'h3C3C, "R2 R7 pattern");
        // R3 enable low holds
        drive(0, 0, 1, 16'h0000, "R3 hold a");
        drive(0, 0, 0, 16'hFFFF, "R3 hold b");
        drive(0, 0, 1, 16'h5A5A, "R3 hold c");
        // R1 reset wins over enable
        drive(1, 1, 0, 16'h0000, "R1 reset with enable");
        // R8 / R4 sweep up to the ceiling
        for (int n = 0; n < 130; n++) drive(0, 1, 0, 16'h0000, "R8 R4 sweep up");
        // R8 / R5 sweep down to the floor
        for (int n = 0; n < 260; n++) drive(0, 1, 1, 16'h0000, "R8 R5 sweep down");
        // floor hold and leave-floor in the same cycle
        drive(0, 1, 1, 16'hF0F0, "R5 R7 mixed at floor");
        drive(0, 1, 0, 16'h0F0F, "R5 R7 mixed at floor 2");
        drive(0, 0, 0, 16'h0000, "R3 hold at floor");
        // climb toward ceiling then mix saturation with steps
        for (int n = 0; n < 256; n++) drive(0, 1, 0, 16'h0000, "R8 R4 second climb");
        drive(0, 1, 1, 16'h00FF, "R4 R7 mixed at ceiling");
        drive(0, 1, 0, 16'h0000, "R4 ceiling hold");
        drive(0, 0, 0, 16'h0000, "flush");
        repeat (3) @(posedge clk);
        report();
    end

endmodule